// File: doc/BRIEF.md
# Coprocessor Register Access Gate

This block sits between a processor's coprocessor move instructions and the register bank of a trace unit. Each request carries the coprocessor number, the primary opcode, three register-select fields, a direction flag and write data, along with the processor's privilege state. The gate decides whether the request belongs to the trace unit. If it does, the gate rebuilds the register number from the instruction fields and then applies the access rules. The result is a completion pulse with read data, an undefined-instruction trap pulse, or nothing at all.

A generation input selects the register numbering scheme. The limited scheme reaches 128 registers with a 7-bit number. The full scheme reaches 1024 registers with a 10-bit number. The block holds a small bank of general registers, starting with a main control register. Within that control register, bit 23 makes the bank read-only to software.

Requests enter as a valid strobe with no ready signal. The gate accepts one request in every cycle in which the strobe is high and never applies back-pressure. Each accepted request receives its response pulse in the next cycle, so a new request may follow every cycle.

Top module: `cpgate_top`

## Requirements
- R1: A request belongs to the block only when the coprocessor number is 14 and opcode_1 is 1. Any other request gets no done pulse and no trap pulse, and it changes no register.
- R2: In the full scheme, the register number is built as bits [9:7] from CRn[2:0], bits [6:4] from opcode_2 and bits [3:0] from CRm.
- R3: In the limited scheme, the register number is {opcode_2, CRm}, which covers registers 0x000 to 0x07F.
- R4: A request made in User mode (priv_mode=0) while the processor is not debug-halted raises rsp_undef, returns zero read data and writes nothing.
- R5: A request made while dbg_halted=1 is treated as privileged, whatever the state of priv_mode.
- R6: When trap_force=1, an owned request traps and writes nothing, even when the processor is privileged.
- R7: Registers 0x3EC and 0x3ED read as zero, and writes to them are discarded. No unlock step is needed before any access.
- R8: Bit 23 of register 0x000 is the read-only bit. A write made while dbg_halted=0 never changes this bit. While the bit is set, every write made with dbg_halted=0 is discarded. Writes made while halted always take effect.
- R9: A privileged request whose CRn lies outside the scheme's range completes with zero read data, and its write is discarded. The full scheme accepts CRn 0 to 7. The limited scheme accepts only CRn 0. A User-mode request with such a CRn traps, as in R4.
- R10: Register 0x079 (CRn=0, CRm=9, opcode_2=7) returns the nonzero constant ID_VALUE in both schemes.
- R11: Registers 0x000 to BANK_DEPTH-1 read back the last value written to them, and they reset to zero. Any other register number reads as zero and does not trap.
- R12: The response appears exactly one cycle after the request is accepted. It is a one-cycle pulse on rsp_done or on rsp_undef, never both. rsp_rdata holds the read value in the rsp_done cycle of a read and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_model | input | 1 | 1 selects the full numbering scheme, 0 selects the limited scheme |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for a move to the coprocessor (write), 0 for a move from it (read) |
| req_cpnum | input | 4 | Coprocessor number |
| req_op1 | input | 3 | opcode_1 field |
| req_crn | input | 4 | CRn field |
| req_crm | input | 4 | CRm field |
| req_op2 | input | 3 | opcode_2 field |
| req_wdata | input | 32 | Write data |
| priv_mode | input | 1 | Processor is in a privileged mode |
| dbg_halted | input | 1 | Processor is halted in debug state |
| trap_force | input | 1 | Processor-side control requests a trap |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| rsp_done | output | 1 | Access completed |
| rsp_undef | output | 1 | Undefined-instruction trap |

## Verification
A single ordered vector table writes to and reads from the bank under each combination of privilege state, halted state, forced trap and numbering scheme. Each read comes after a write that would have changed its result if the rule under test were broken.

Some writes use CRn, opcode_2 or CRm values that would alias a known register if a field were dropped or placed at the wrong bit position. These writes separate a correct number mapping from a misplaced one.

Out-of-range CRn values, foreign coprocessor numbers, the lock register numbers and the read-only sequence (a software set attempt, a debugger set, a blocked software write, a debugger clear) separate a gate that discards writes from one that merely masks the read data. Directed tests then check the pulse length, the idle read data and the register contents after a second reset.

// File: rtl/cpgate_pkg.sv
package cpgate_pkg;
  localparam int          REGNUM_W    = 10;
  localparam logic [3:0]  CP_OWNED    = 4'd14;
  localparam logic [2:0]  OP1_OWNED   = 3'd1;
  localparam int          CTRL_RO_BIT = 23;
  localparam logic [9:0]  NUM_ID      = 10'h079;
  localparam logic [9:0]  NUM_LOCK_A  = 10'h3EC;
  localparam logic [9:0]  NUM_LOCK_B  = 10'h3ED;

  typedef logic [REGNUM_W-1:0] regnum_t;
endpackage

// File: rtl/cpgate_decode.sv
module cpgate_decode
  import cpgate_pkg::*;
(
  input  logic       full_model,
  input  logic [3:0] cpnum,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       owned,
  output logic       crn_ok,
  output regnum_t    regnum
);
  // Ownership: coprocessor 14, opcode_1 == 1
  assign owned = (cpnum == CP_OWNED) && (op1 == OP1_OWNED);

  // Scheme-dependent CRn range and number assembly
  always_comb begin
    if (full_model) begin
      crn_ok = ~crn[3];
      regnum = {crn[2:0], op2, crm};
    end else begin
      crn_ok = (crn == 4'd0);
      regnum = {3'b000, op2, crm};
    end
  end
endmodule

// File: rtl/cpgate_regbank.sv
module cpgate_regbank
  import cpgate_pkg::*;
#(
  parameter int          BANK_DEPTH = 32,
  parameter logic [31:0] ID_VALUE   = 32'h1A2B_0C3D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  regnum_t     num,
  input  logic        wr_req,
  input  logic [31:0] wdata,
  input  logic        halted,
  output logic [31:0] rd_data
);
  localparam int IDX_W = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;

  logic [31:0] regs_q [BANK_DEPTH];
  logic        in_bank;
  logic        ro_q;
  logic        wr_allow;
  logic [IDX_W-1:0] idx;

  assign in_bank  = (int'(num) < BANK_DEPTH);
  assign idx      = num[IDX_W-1:0];
  assign ro_q     = regs_q[0][CTRL_RO_BIT];
  // Debugger writes always pass; software writes pass only while not read-only
  assign wr_allow = wr_req && in_bank && (halted || !ro_q);

  for (genvar g = 0; g < BANK_DEPTH; g++) begin : g_reg
    logic hit;
    assign hit = wr_allow && (idx == IDX_W'(g));
    if (g == 0) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          regs_q[g] <= '0;
        end else if (hit) begin
          regs_q[g] <= wdata;
          if (!halted) regs_q[g][CTRL_RO_BIT] <= regs_q[g][CTRL_RO_BIT];
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)   regs_q[g] <= '0;
        else if (hit) regs_q[g] <= wdata;
      end
    end
  end

  // Lock numbers take priority over everything else: read as zero
  always_comb begin
    if (num == NUM_LOCK_A || num == NUM_LOCK_B) rd_data = '0;
    else if (num == NUM_ID)                     rd_data = ID_VALUE;
    else if (in_bank)                           rd_data = regs_q[idx];
    else                                        rd_data = '0;
  end

  // R8: software can never change the read-only bit
  p_ro_bit_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !halted) |=> $stable(regs_q[0][CTRL_RO_BIT]));
  // R8: while read-only, software writes leave the control register alone
  p_ro_blocks_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !halted && ro_q) |=> $stable(regs_q[0]));
endmodule

// File: rtl/cpgate_top.sv
module cpgate_top
  import cpgate_pkg::*;
#(
  parameter int          BANK_DEPTH = 32,
  parameter logic [31:0] ID_VALUE   = 32'h1A2B_0C3D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        full_model,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [3:0]  req_cpnum,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic [31:0] req_wdata,
  input  logic        priv_mode,
  input  logic        dbg_halted,
  input  logic        trap_force,
  output logic [31:0] rsp_rdata,
  output logic        rsp_done,
  output logic        rsp_undef
);
  logic        owned, crn_ok;
  regnum_t     regnum;
  logic        accept, trap, live, wr_req;
  logic [31:0] bank_rdata;

  cpgate_decode u_decode (
    .full_model (full_model),
    .cpnum      (req_cpnum),
    .op1        (req_op1),
    .crn        (req_crn),
    .crm        (req_crm),
    .op2        (req_op2),
    .owned      (owned),
    .crn_ok     (crn_ok),
    .regnum     (regnum)
  );

  assign accept = req_valid && owned;
  // Halted counts as privileged; a forced trap overrides privilege
  assign trap   = trap_force || !(priv_mode || dbg_halted);
  assign live   = accept && !trap && crn_ok;
  assign wr_req = live && req_write;

  cpgate_regbank #(
    .BANK_DEPTH (BANK_DEPTH),
    .ID_VALUE   (ID_VALUE)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .num     (regnum),
    .wr_req  (wr_req),
    .wdata   (req_wdata),
    .halted  (dbg_halted),
    .rd_data (bank_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_undef <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done  <= accept && !trap;
      rsp_undef <= accept && trap;
      rsp_rdata <= (live && !req_write) ? bank_rdata : '0;
    end
  end

  // R12: never both pulses
  p_one_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_undef));
  // R12: a response always follows a request one cycle earlier
  p_resp_follows_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_undef) |-> $past(req_valid));
  // R12: read data is zero outside a completion
  p_rdata_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> (rsp_rdata == '0));
  // R1: foreign requests get no response
  p_foreign_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !owned) |=> !(rsp_done || rsp_undef));
  // R4: unhalted User mode traps
  p_user_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !priv_mode && !dbg_halted) |=> (rsp_undef && rsp_rdata == '0));
  // R7: lock registers read as zero
  p_lock_raz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !req_write && (regnum == NUM_LOCK_A || regnum == NUM_LOCK_B))
      |=> (rsp_done && rsp_rdata == '0));
endmodule

// File: tb/cpgate_top_bench.sv
module cpgate_top_bench;
  localparam logic [31:0] IDV = 32'h1A2B_0C3D;

  typedef struct packed {
    logic        full;
    logic        wr;
    logic [3:0]  cp;
    logic [2:0]  op1;
    logic [3:0]  crn;
    logic [3:0]  crm;
    logic [2:0]  op2;
    logic [31:0] wd;
    logic        priv;
    logic        halt;
    logic        frc;
    logic        exd;
    logic        exu;
    logic [31:0] exr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 44;
  // full wr cp op1 crn crm op2 wdata priv halt frc | done undef rdata | req
  localparam vec_t V [NV] = '{
    '{1,1,14,1,0,5,0,32'hAAAA5555,1,0,0, 1,0,32'h0,         11}, // R11 write 0x005
    '{1,0,14,1,0,5,0,32'h0,       1,0,0, 1,0,32'hAAAA5555,  11}, // R11 read back
    '{1,1,14,1,0,3,1,32'h0000013C,1,0,0, 1,0,32'h0,          2}, // R2 write 0x013
    '{1,0,14,1,0,3,1,32'h0,       1,0,0, 1,0,32'h0000013C,   2}, // R2 read 0x013
    '{1,0,14,1,0,3,0,32'h0,       1,0,0, 1,0,32'h0,          2}, // R2 0x003 untouched
    '{1,1,14,1,1,5,0,32'hDEADBEEF,1,0,0, 1,0,32'h0,          2}, // R2 write 0x085
    '{1,0,14,1,0,5,0,32'h0,       1,0,0, 1,0,32'hAAAA5555,   2}, // R2 0x005 not aliased
    '{1,0,14,1,1,5,0,32'h0,       1,0,0, 1,0,32'h0,         11}, // R11 unimplemented RAZ
    '{0,0,14,1,0,5,0,32'h0,       1,0,0, 1,0,32'hAAAA5555,   3}, // R3 limited read
    '{0,1,14,1,1,5,0,32'h11112222,1,0,0, 1,0,32'h0,          9}, // R9 limited CRn=1 write
    '{0,0,14,1,0,5,0,32'h0,       1,0,0, 1,0,32'hAAAA5555,   9}, // R9 discarded
    '{1,0,14,1,0,9,7,32'h0,       1,0,0, 1,0,IDV,           10}, // R10 full ID
    '{0,0,14,1,0,9,7,32'h0,       1,0,0, 1,0,IDV,           10}, // R10 limited ID
    '{1,0,14,1,8,5,0,32'h0,       1,0,0, 1,0,32'h0,          9}, // R9 CRn=8 read
    '{1,1,14,1,8,5,0,32'h77777777,1,0,0, 1,0,32'h0,          9}, // R9 CRn=8 write
    '{1,0,14,1,0,5,0,32'h0,       1,0,0, 1,0,32'hAAAA5555,   9}, // R9 discarded
    '{1,0,14,1,0,5,0,32'h0,       0,0,0, 0,1,32'h0,          4}, // R4 user read
    '{1,1,14,1,0,5,0,32'h99999999,0,0,0, 0,1,32'h0,          4}, // R4 user write
    '{1,0,14,1,0,5,0,32'h0,       1,0,0, 1,0,32'hAAAA5555,   4}, // R4 unchanged
    '{1,1,14,1,0,5,0,32'h0BADF00D,0,1,0, 1,0,32'h0,          5}, // R5 halted user write
    '{1,0,14,1,0,5,0,32'h0,       0,1,0, 1,0,32'h0BADF00D,   5}, // R5 halted user read
    '{1,0,14,1,0,5,0,32'h0,       1,0,1, 0,1,32'h0,          6}, // R6 forced trap read
    '{1,1,14,1,0,5,0,32'h00000055,1,0,1, 0,1,32'h0,          6}, // R6 forced trap write
    '{1,0,14,1,0,5,0,32'h0,       1,0,0, 1,0,32'h0BADF00D,   6}, // R6 unchanged
    '{1,0,15,1,0,5,0,32'h0,       1,0,0, 0,0,32'h0,          1}, // R1 cp15
    '{1,1,14,0,0,5,0,32'h12344321,1,0,0, 0,0,32'h0,          1}, // R1 op1=0 write
    '{1,0,14,1,0,5,0,32'h0,       1,0,0, 1,0,32'h0BADF00D,   1}, // R1 unchanged
    '{1,0,14,1,8,5,0,32'h0,       0,0,0, 0,1,32'h0,          9}, // R9 user CRn=8 traps
    '{1,1,14,1,7,12,6,32'hFFFFFFFF,1,0,0,1,0,32'h0,          7}, // R7 write 0x3EC
    '{1,0,14,1,7,12,6,32'h0,      1,0,0, 1,0,32'h0,          7}, // R7 read 0x3EC
    '{1,0,14,1,7,13,6,32'h0,      1,0,0, 1,0,32'h0,          7}, // R7 read 0x3ED
    '{1,1,14,1,0,0,0,32'h00800001,1,0,0, 1,0,32'h0,          8}, // R8 sw cannot set bit 23
    '{1,0,14,1,0,0,0,32'h0,       1,0,0, 1,0,32'h00000001,   8}, // R8
    '{1,1,14,1,0,0,0,32'h00800003,1,1,0, 1,0,32'h0,          8}, // R8 debugger sets
    '{1,0,14,1,0,0,0,32'h0,       1,0,0, 1,0,32'h00800003,   8}, // R8
    '{1,1,14,1,0,5,0,32'h12121212,1,0,0, 1,0,32'h0,          8}, // R8 sw write blocked
    '{1,0,14,1,0,5,0,32'h0,       1,0,0, 1,0,32'h0BADF00D,   8}, // R8
    '{1,1,14,1,0,0,0,32'h00000000,1,0,0, 1,0,32'h0,          8}, // R8 sw clear blocked
    '{1,0,14,1,0,0,0,32'h0,       1,0,0, 1,0,32'h00800003,   8}, // R8
    '{1,1,14,1,0,5,0,32'h34343434,1,1,0, 1,0,32'h0,          8}, // R8 debugger write
    '{1,0,14,1,0,5,0,32'h0,       1,0,0, 1,0,32'h34343434,   8}, // R8
    '{1,1,14,1,0,0,0,32'h00000000,1,1,0, 1,0,32'h0,          8}, // R8 debugger clears
    '{1,1,14,1,0,5,0,32'h56565656,1,0,0, 1,0,32'h0,          8}, // R8 sw write again
    '{1,0,14,1,0,5,0,32'h0,       1,0,0, 1,0,32'h56565656,   8}  // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        full_model = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_cpnum = '0, req_crn = '0, req_crm = '0;
  logic [2:0]  req_op1 = '0, req_op2 = '0;
  logic [31:0] req_wdata = '0;
  logic        priv_mode = 1'b1, dbg_halted = 1'b0, trap_force = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_done, rsp_undef;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cpgate_top u_cpgate_top (
    .clk(clk), .rst_n(rst_n), .full_model(full_model),
    .req_valid(req_valid), .req_write(req_write), .req_cpnum(req_cpnum),
    .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
    .req_wdata(req_wdata), .priv_mode(priv_mode), .dbg_halted(dbg_halted),
    .trap_force(trap_force), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .rsp_undef(rsp_undef)
  );

  task automatic check(input string tag, input logic d, input logic u,
                       input logic [31:0] r);
    tests++;
    if (rsp_done !== d || rsp_undef !== u || rsp_rdata !== r) begin
      fails++;
      $display("FAIL %s: got done=%0b undef=%0b rdata=%h, expected done=%0b undef=%0b rdata=%h",
               tag, rsp_done, rsp_undef, rsp_rdata, d, u, r);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid  = 1'b1;
    full_model = v.full;
    req_write  = v.wr;
    req_cpnum  = v.cp;
    req_op1    = v.op1;
    req_crn    = v.crn;
    req_crm    = v.crm;
    req_op2    = v.op2;
    req_wdata  = v.wd;
    priv_mode  = v.priv;
    dbg_halted = v.halt;
    trap_force = v.frc;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0; dbg_halted = 1'b0;
    trap_force = 1'b0; priv_mode = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset state", 1'b0, 1'b0, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 idle after reset", 1'b0, 1'b0, 32'h0);

    // Vector walk: drive at a falling edge, sample one cycle later
    for (int i = 0; i < NV; i++) begin
      drive(V[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", V[i].req, i), V[i].exd, V[i].exu, V[i].exr);
    end

    // R12: response is a single-cycle pulse and rdata returns to zero
    idle();
    @(negedge clk);
    check("R12 pulse ends", 1'b0, 1'b0, 32'h0);

    // R12: back-to-back reads each answered in the following cycle
    drive('{1,0,14,1,0,9,7,32'h0,1,0,0,0,0,32'h0,0});
    @(negedge clk);
    check("R12 first of pair", 1'b1, 1'b0, IDV);
    drive('{1,0,14,1,0,5,0,32'h0,1,0,0,0,0,32'h0,0});
    @(negedge clk);
    check("R12 second of pair", 1'b1, 1'b0, 32'h56565656);
    idle();
    @(negedge clk);
    check("R12 idle again", 1'b0, 1'b0, 32'h0);

    // R11: a second reset clears the bank
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive('{1,0,14,1,0,5,0,32'h0,1,0,0,0,0,32'h0,0});
    @(negedge clk);
    check("R11 reset clears 0x005", 1'b1, 1'b0, 32'h0);
    drive('{1,0,14,1,0,0,0,32'h0,1,0,0,0,0,32'h0,0});
    @(negedge clk);
    check("R11 reset clears control", 1'b1, 1'b0, 32'h0);
    // R8: read-only bit cleared by reset, so software writes land
    drive('{1,1,14,1,0,5,0,32'h0000BEEF,1,0,0,0,0,32'h0,0});
    @(negedge clk);
    drive('{1,0,14,1,0,5,0,32'h0,1,0,0,0,0,32'h0,0});
    @(negedge clk);
    check("R8 writable after reset", 1'b1, 1'b0, 32'h0000BEEF);
    idle();
    @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule